// File: doc/BRIEF.md
# Instruction Word Prefetch Queue

This block is a short queue of 16-bit instruction words placed between a 32-bit long-word holding register and an opcode decoder. A control sequencer asks for words one at a time with a prefetch request. The holding register is loaded with a whole long word from the instruction cache or the external bus. Each accepted request then copies one halfword of it into the queue. Words move toward the decode stage, which is the only stage the decoder sees. Every word carries a bus-fault flag taken from the long word it came from.

The queue has three stages: an entry stage, a middle stage and a decode stage. The stages stay packed toward the decode end, so a new word lands in the free stage nearest to decode. A consume pulse from the decoder removes the decode word, and the remaining words move one stage forward. Bit 1 of the prefetch pointer chooses which halfword of a long word is used first. The upper halfword is used before the lower one. A flush on a change of flow empties the queue and the holding register in one cycle, and it loads the new halfword pointer. A faulted word raises a fault only when the decoder tries to consume it.

Top module: `iword_queue`

## Requirements
- R1: After reset all stages and the holding register are empty and the halfword pointer is 0. `dec_valid_o`, `lw_req_o`, `pf_stall_o` and `dec_fault_o` are 0 while no request is applied.
- R2: `lw_req_o` is 1 exactly when `pf_req_i` is 1, the holding register is empty and `flush_i` is 0. The holding register loads `lw_data_i` and `lw_fault_i` at an edge where `lw_valid_i` is 1, it is empty and no flush is applied. `lw_valid_i` is ignored while the register is full.
- R3: A halfword pointer of 0 selects `lw_data_i[31:16]` and a pointer of 1 selects `[15:0]`. After the upper halfword is taken, the next accepted request takes the lower halfword of the same long word without raising `lw_req_o`. After the lower halfword is taken, the holding register is empty and the pointer returns to 0.
- R4: Words reach `dec_word_o` in the order in which their requests were accepted. A consume pulse with `dec_valid_o` high removes the decode word and moves the remaining words one stage forward.
- R5: Stages change only on an accepted prefetch request, a consume or a flush. With none of these, the queue contents stay the same.
- R6: A request is accepted when the holding register is full, no flush is applied, and either a stage is free or a consume happens in the same cycle. `pf_stall_o` is `pf_req_i` AND NOT accepted. In particular, it is 1 when all three stages are full and no consume is applied.
- R7: A word keeps the fault flag of its long word. `dec_fault_o` is 1 only in a cycle where `dec_take_i` is 1 and the decode stage holds a valid, faulted word.
- R8: `flush_i` empties all stages and the holding register at the next edge. It sets the halfword pointer to `flush_a1_i`. In that cycle it overrides any request, consume and fill.
- R9: A consume pulse while the decode stage is empty has no effect.
- R10: A word accepted while the queue is empty appears on `dec_word_o` with `dec_valid_o` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_req_i | input | 1 | Prefetch request from the sequencer, held until accepted |
| pf_stall_o | output | 1 | Request not accepted this cycle |
| flush_i | input | 1 | Change-of-flow flush |
| flush_a1_i | input | 1 | Halfword pointer (address bit 1) loaded on a flush |
| lw_req_o | output | 1 | Long-word fetch request to cache or bus |
| lw_valid_i | input | 1 | Long word available on `lw_data_i` |
| lw_data_i | input | 32 | Long word |
| lw_fault_i | input | 1 | Long word came from an abnormally ended bus cycle |
| dec_take_i | input | 1 | Decoder consumes the decode-stage word |
| dec_valid_o | output | 1 | Decode stage holds a word |
| dec_word_o | output | 16 | Decode-stage word |
| dec_fault_o | output | 1 | Decoder consumed a faulted word |

## Verification
The assertions check on every cycle that the stages stay packed toward decode, that no word is pushed into a full queue, that the stages hold still without a request, consume or flush, and that the holding register captures, steps from the upper to the lower halfword, and empties. They also check that a flush leaves everything empty. Only the bench scenarios show the end-to-end properties: words keep their order across many accepts and consumes, fault flags stay attached to the right words through the stages, a flush to an odd halfword yields only the lower halfword, and a full queue accepts a request together with a consume.

// File: rtl/iwq_pkg.sv
package iwq_pkg;

    // Halfword pointer: value of prefetch address bit 1.
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_sel_e;

endpackage

// File: rtl/iwq_holdreg.sv
module iwq_holdreg
    import iwq_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                flush_a1_i,
    input  logic                fill_i,
    input  logic [2*WORD_W-1:0] fill_data_i,
    input  logic                fill_flt_i,
    input  logic                take_i,
    output logic                vld_o,
    output logic [WORD_W-1:0]   word_o,
    output logic                flt_o
);

    localparam int unsigned LW_W = 2 * WORD_W;

    typedef struct packed {
        logic        vld;
        logic        flt;
        half_sel_e   sel;
        logic [LW_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (flush_i) begin
            h_d.vld = 1'b0;
            h_d.flt = 1'b0;
            h_d.sel = half_sel_e'(flush_a1_i);
        end else begin
            if (take_i && h_q.vld) begin
                if (h_q.sel == HALF_LOWER) begin
                    h_d.vld = 1'b0;
                    h_d.sel = HALF_UPPER;
                end else begin
                    h_d.sel = HALF_LOWER;
                end
            end
            if (!h_q.vld && fill_i) begin
                h_d.vld  = 1'b1;
                h_d.flt  = fill_flt_i;
                h_d.data = fill_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign vld_o  = h_q.vld;
    assign flt_o  = h_q.flt;
    assign word_o = (h_q.sel == HALF_LOWER) ? h_q.data[WORD_W-1:0]
                                            : h_q.data[LW_W-1:WORD_W];

    a_r2_fill_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && fill_i && !h_q.vld) |=>
            (h_q.vld && h_q.data == $past(fill_data_i) && h_q.flt == $past(fill_flt_i)));

    a_r3_lower_follows_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && take_i && h_q.vld && h_q.sel == HALF_UPPER) |=>
            (h_q.vld && h_q.sel == HALF_LOWER && $stable(h_q.data)));

    a_r3_lower_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && take_i && h_q.vld && h_q.sel == HALF_LOWER) |=>
            (!h_q.vld && h_q.sel == HALF_UPPER));

    a_r8_flush_empties_hold: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!h_q.vld && h_q.sel == half_sel_e'($past(flush_a1_i))));

endmodule

// File: rtl/iwq_stages.sv
module iwq_stages #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_word_i,
    input  logic              push_flt_i,
    input  logic              pop_i,
    output logic              head_vld_o,
    output logic [WORD_W-1:0] head_word_o,
    output logic              head_flt_o,
    output logic              full_o
);

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [WORD_W-1:0] word;
    } slot_t;

    // Slot 0 is the decode stage, slot DEPTH-1 the entry stage.
    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } pipe_t;

    pipe_t p_d, p_q;
    logic  pop_ok;
    logic  placed;

    assign pop_ok = pop_i && p_q.slot[0].vld;

    always_comb begin
        p_d    = p_q;
        placed = 1'b0;
        if (pop_ok) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                p_d.slot[i] = p_q.slot[i+1];
            end
            p_d.slot[DEPTH-1] = '0;
        end
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (push_i && !placed && !p_d.slot[i].vld) begin
                p_d.slot[i].vld  = 1'b1;
                p_d.slot[i].flt  = push_flt_i;
                p_d.slot[i].word = push_word_i;
                placed           = 1'b1;
            end
        end
        if (flush_i) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign head_vld_o  = p_q.slot[0].vld;
    assign head_word_o = p_q.slot[0].word;
    assign head_flt_o  = p_q.slot[0].flt;
    assign full_o      = p_q.slot[DEPTH-1].vld;

    generate
        for (genvar g = 0; g < int'(DEPTH) - 1; g++) begin : g_pack
            a_r4_packed: assert property (@(posedge clk) disable iff (!rst_n)
                p_q.slot[g+1].vld |-> p_q.slot[g].vld);
        end
    endgenerate

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> (!p_q.slot[DEPTH-1].vld || pop_ok));

    a_r5_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !push_i && !pop_i) |=> $stable(p_q));

    a_r8_flush_empties_stages: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !p_q.slot[0].vld);

    a_r10_direct_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && push_i && !p_q.slot[0].vld) |=>
            (p_q.slot[0].vld && p_q.slot[0].word == $past(push_word_i)));

endmodule

// File: rtl/iword_queue.sv
module iword_queue #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pf_req_i,
    output logic                pf_stall_o,
    input  logic                flush_i,
    input  logic                flush_a1_i,
    output logic                lw_req_o,
    input  logic                lw_valid_i,
    input  logic [2*WORD_W-1:0] lw_data_i,
    input  logic                lw_fault_i,
    input  logic                dec_take_i,
    output logic                dec_valid_o,
    output logic [WORD_W-1:0]   dec_word_o,
    output logic                dec_fault_o
);

    logic              hold_vld;
    logic [WORD_W-1:0] hold_word;
    logic              hold_flt;
    logic              q_full;
    logic              head_vld;
    logic              head_flt;
    logic              accept;
    logic              consume;

    assign consume = dec_take_i && head_vld && !flush_i;
    assign accept  = pf_req_i && hold_vld && !flush_i && (!q_full || consume);

    iwq_holdreg #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .flush_a1_i (flush_a1_i),
        .fill_i     (lw_valid_i),
        .fill_data_i(lw_data_i),
        .fill_flt_i (lw_fault_i),
        .take_i     (accept),
        .vld_o      (hold_vld),
        .word_o     (hold_word),
        .flt_o      (hold_flt)
    );

    iwq_stages #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stages (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .push_i     (accept),
        .push_word_i(hold_word),
        .push_flt_i (hold_flt),
        .pop_i      (dec_take_i),
        .head_vld_o (head_vld),
        .head_word_o(dec_word_o),
        .head_flt_o (head_flt),
        .full_o     (q_full)
    );

    assign pf_stall_o  = pf_req_i && !accept;
    assign lw_req_o    = pf_req_i && !hold_vld && !flush_i;
    assign dec_valid_o = head_vld;
    assign dec_fault_o = dec_take_i && head_vld && head_flt;

    a_r9_empty_take_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_vld && dec_take_i && !accept) |=> !dec_valid_o);

    a_r2_no_fetch_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !flush_i && !accept) |=> !lw_req_o);

endmodule

// File: tb/test_iword_queue.sv
module test_iword_queue;

    localparam int unsigned W = 16;
    localparam int unsigned D = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_req = 1'b0;
    logic          pf_stall;
    logic          flush = 1'b0;
    logic          flush_a1 = 1'b0;
    logic          lw_req;
    logic          lw_valid = 1'b0;
    logic [2*W-1:0] lw_data = '0;
    logic          lw_fault = 1'b0;
    logic          take = 1'b0;
    logic          dec_valid;
    logic [W-1:0]  dec_word;
    logic          dec_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iword_queue #(.WORD_W(W), .DEPTH(D)) i_iword_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pf_req_i   (pf_req),
        .pf_stall_o (pf_stall),
        .flush_i    (flush),
        .flush_a1_i (flush_a1),
        .lw_req_o   (lw_req),
        .lw_valid_i (lw_valid),
        .lw_data_i  (lw_data),
        .lw_fault_i (lw_fault),
        .dec_take_i (take),
        .dec_valid_o(dec_valid),
        .dec_word_o (dec_word),
        .dec_fault_o(dec_fault)
    );

    typedef struct {
        logic [W-1:0] w;
        logic         f;
    } exp_t;

    exp_t           sb[$];
    logic           m_hv   = 1'b0;
    logic           m_sel  = 1'b0;
    logic           m_flt  = 1'b0;
    logic [2*W-1:0] m_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: compares at the falling edge, then advances the model
    // to the state the next rising edge will produce.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit pop, acc, fill, exp_lw, exp_flt;
            exp_t e;
            pop     = take && sb.size() > 0;
            acc     = pf_req && m_hv && !flush && (sb.size() < D || pop);
            fill    = !m_hv && lw_valid;
            exp_lw  = pf_req && !m_hv && !flush;
            exp_flt = pop ? sb[0].f : 1'b0;
            chk(lw_req == exp_lw, "R2 long-word request", 32'(lw_req), 32'(exp_lw));
            chk(pf_stall == (pf_req && !acc), "R6 stall", 32'(pf_stall), 32'(pf_req && !acc));
            chk(dec_valid == (sb.size() > 0), "R5 R9 R10 decode valid",
                32'(dec_valid), 32'(sb.size() > 0));
            if (sb.size() > 0)
                chk(dec_word == sb[0].w, "R3 R4 decode word", 32'(dec_word), 32'(sb[0].w));
            chk(dec_fault == exp_flt, "R7 fault at decode", 32'(dec_fault), 32'(exp_flt));
            if (flush) begin
                sb.delete();
                m_hv  = 1'b0;
                m_flt = 1'b0;
                m_sel = flush_a1;
            end else begin
                if (pop) void'(sb.pop_front());
                if (acc) begin
                    e.w = m_sel ? m_data[W-1:0] : m_data[2*W-1:W];
                    e.f = m_flt;
                    sb.push_back(e);
                    if (m_sel) begin
                        m_hv  = 1'b0;
                        m_sel = 1'b0;
                    end else begin
                        m_sel = 1'b1;
                    end
                end
                if (fill) begin
                    m_hv   = 1'b1;
                    m_data = lw_data;
                    m_flt  = lw_fault;
                end
            end
        end
    end

    task automatic drive(input bit req, input bit tk, input bit fl, input bit fa1,
                         input bit lwv, input logic [31:0] data, input bit flt);
        @(posedge clk);
        #1;
        pf_req   = req;
        take     = tk;
        flush    = fl;
        flush_a1 = fa1;
        lw_valid = lwv;
        lw_data  = data;
        lw_fault = flt;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dec_valid == 1'b0, "R1 reset decode valid", 32'(dec_valid), 0);
        chk(lw_req == 1'b0, "R1 reset long-word request", 32'(lw_req), 0);
        chk(pf_stall == 1'b0, "R1 reset stall", 32'(pf_stall), 0);

        // R2 R10: first fetch lands in decode one cycle after accept
        drive(1, 0, 0, 0, 1, 32'h1111_2222, 0);
        @(negedge clk);
        chk(lw_req == 1'b1, "R2 request on empty hold", 32'(lw_req), 1);
        drive(1, 0, 0, 0, 0, 32'h0, 0);
        drive(1, 0, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        chk(dec_word == 16'h1111, "R10 upper word at decode", 32'(dec_word), 32'h1111);
        chk(lw_req == 1'b0, "R3 no fetch for lower half", 32'(lw_req), 0);

        // R6: fill all stages with a faulted long word, then stall
        drive(1, 0, 0, 0, 1, 32'h3333_4444, 1);
        repeat (4) drive(1, 0, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        chk(pf_stall == 1'b1, "R6 stall when full", 32'(pf_stall), 1);
        // accept together with consume while full
        drive(1, 1, 0, 0, 0, 32'h0, 0);
        drive(0, 1, 0, 0, 0, 32'h0, 0);
        drive(0, 1, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        chk(dec_fault == 1'b1, "R7 faulted word consumed", 32'(dec_fault), 1);
        drive(0, 0, 0, 0, 1, 32'h5555_6666, 0);
        drive(0, 0, 0, 0, 0, 32'h0, 0);

        // R8: flush to an odd halfword
        drive(1, 1, 1, 1, 1, 32'h7777_8888, 0);
        @(negedge clk);
        chk(pf_stall == 1'b1, "R8 request ignored in flush cycle", 32'(pf_stall), 1);
        drive(1, 0, 0, 0, 1, 32'hAAAA_BBBB, 0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R8 empty after flush", 32'(dec_valid), 0);
        drive(1, 0, 0, 0, 0, 32'h0, 0);
        drive(0, 0, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        chk(dec_word == 16'hBBBB, "R8 lower half after odd flush", 32'(dec_word), 32'hBBBB);

        // R9: consume on empty is ignored
        drive(0, 1, 0, 0, 0, 32'h0, 0);
        drive(0, 1, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R9 consume while empty", 32'(dec_valid), 0);

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 40) == 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 5) == 0);
        end
        drive(0, 0, 0, 0, 0, 32'h0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule